// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog counter behind a small 16-bit register bus. While it is enabled it counts down by one on each pulse of a tick enable input, which the system drives once every 10 ms. If software stops reloading it, the block first raises a warning interrupt. One tick later it asserts a one-cycle system reset, latches a sticky timed-out status and reloads itself from the timeout value.

Every state change needs a 16-bit key value written to the right register, so a stray bus write cannot stop or disturb the watchdog. Reloading, re-enabling and clearing the status each take their own key. Disabling takes two keys, written to two registers one after the other. A debug-mode input can hold the count still unless software has set an override bit.

The control core is a three-state machine. `S_OFF` means the timer is disabled. `S_RUN` means it is counting. `S_ARMED` means it is counting and the first disable key has been accepted. The transitions are:
- restart key: `S_OFF` to `S_RUN`.
- first disable key: `S_RUN` to `S_ARMED`.
- second disable key: `S_ARMED` to `S_OFF`.
- cancel (any other write to either disable register): `S_ARMED` back to `S_RUN`.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the disable2 register (0x0C) reads 0xDABE (disabled), timeout (0x04) reads 6000 (0x1770), mask (0x24) reads 0, status (0x10) reads 0, and irq and wdt_reset are low.
- R2: A write to timeout (0x04) stores bits 14:0 of the data. It reads back with bit 15 zero.
- R3: Writing 0xFEED to the feed register (0x00) reloads the counter from timeout; any other value leaves the count unchanged. A feed and a tick in the same cycle leave the count equal to the timeout value.
- R4: Writing 0xACED to restart (0x1C) enables the timer from the count it holds. While enabled, each tick lowers the count by one. While disabled, ticks are ignored.
- R5: 0x2BAD written to disable1 (0x08), followed by 0xCAFE written to disable2 (0x0C), disables the timer. If disable1 has not received its key, or a non-key write to 0x08 or 0x0C comes between the two keys, the 0xCAFE write has no effect. Disable2 reads 0xDABE while disabled and 0x0000 while enabled.
- R6: The count register (0x14) gives the count in bits 14:0. Bit 15 reads 1 in the cycle after the count was loaded or stepped, and 0 otherwise.
- R7: A tick that takes the count from 1 to 0 sets bit 0 of the event register (0x20). The next tick, with the count at 0, asserts wdt_reset.
- R8: wdt_reset is high for one cycle per timeout. On that timeout the counter reloads from timeout and the timer stays enabled.
- R9: Status (0x10) reads 0xCFE8 once a timeout has pulsed wdt_reset. Writing 0xE8B4 clears it to 0x0000, and other values written there are ignored.
- R10: irq equals event bit 0 AND mask (0x24) bit 0. Writing a 1 in bit 0 of the event register clears the event.
- R11: Writing a 1 in bit 0 of force (0x28) sets the event.
- R12: Debug register (0x18) bit 1 reflects the dbg_mode input and bit 0 is a writable override. While dbg_mode is high and the override is 0, ticks do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse per 10 ms tick |
| dbg_mode | input | 1 | Debugger attached; holds the count unless overridden |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Warning interrupt, masked |
| wdt_reset | output | 1 | One-cycle system reset request |

## Verification
The hardest state to reach is the two-step warning-then-reset window. The count has to be walked down to 1 and then to 0 by single ticks while the event, the mask and the reset pulse are watched on separate cycles. The stimulus programs a timeout of 3, feeds, restarts and issues ticks one at a time. This places the event and the reset on known cycles. The key sequence is then attacked with a lone second key, and with a cancelling write between the two keys, before the real sequence is applied.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int DATA_W = 16;
    localparam int REG_N  = 11;

    // Register index; byte offset = index * 4 (software-visible order)
    typedef enum logic [3:0] {
        RG_FEED    = 4'd0,
        RG_TMO     = 4'd1,
        RG_DIS1    = 4'd2,
        RG_DIS2    = 4'd3,
        RG_STAT    = 4'd4,
        RG_CNT     = 4'd5,
        RG_DBG     = 4'd6,
        RG_RESTART = 4'd7,
        RG_EVT     = 4'd8,
        RG_MASK    = 4'd9,
        RG_FORCE   = 4'd10
    } reg_idx_e;

    localparam logic [DATA_W-1:0] KEY_FEED     = 16'hFEED;
    localparam logic [DATA_W-1:0] KEY_DIS1     = 16'h2BAD;
    localparam logic [DATA_W-1:0] KEY_DIS2     = 16'hCAFE;
    localparam logic [DATA_W-1:0] KEY_RESTART  = 16'hACED;
    localparam logic [DATA_W-1:0] KEY_STAT_CLR = 16'hE8B4;

    localparam logic [DATA_W-1:0] CODE_OFF     = 16'hDABE;
    localparam logic [DATA_W-1:0] CODE_ON      = 16'h0000;
    localparam logic [DATA_W-1:0] CODE_EXPIRED = 16'hCFE8;
    localparam logic [DATA_W-1:0] CODE_NORMAL  = 16'h0000;

    typedef enum logic [1:0] {
        S_OFF   = 2'd0,
        S_RUN   = 2'd1,
        S_ARMED = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic feed_key;
        logic restart_key;
        logic dis1_key;
        logic dis1_other;
        logic dis2_key;
        logic dis2_other;
        logic stat_clr;
        logic tmo_wr;
        logic dbg_wr;
        logic evt_ack;
        logic mask_wr;
        logic force_set;
    } wr_evt_t;

endpackage

// File: rtl/kwd_bus_dec.sv
module kwd_bus_dec
    import kwd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output wr_evt_t           wr_evt
);

    logic [REG_N-1:0] sel;

    // One-hot register select, one comparator per word slot
    for (genvar i = 0; i < REG_N; i++) begin : g_sel
        assign sel[i] = bus_we && (bus_addr == ADDR_W'(i * 4));
    end

    always_comb begin
        wr_evt = '0;
        wr_evt.feed_key    = sel[RG_FEED]    && (bus_wdata == KEY_FEED);      // R3
        wr_evt.restart_key = sel[RG_RESTART] && (bus_wdata == KEY_RESTART);   // R4
        wr_evt.dis1_key    = sel[RG_DIS1]    && (bus_wdata == KEY_DIS1);      // R5
        wr_evt.dis1_other  = sel[RG_DIS1]    && (bus_wdata != KEY_DIS1);
        wr_evt.dis2_key    = sel[RG_DIS2]    && (bus_wdata == KEY_DIS2);
        wr_evt.dis2_other  = sel[RG_DIS2]    && (bus_wdata != KEY_DIS2);
        wr_evt.stat_clr    = sel[RG_STAT]    && (bus_wdata == KEY_STAT_CLR);  // R9
        wr_evt.tmo_wr      = sel[RG_TMO];
        wr_evt.dbg_wr      = sel[RG_DBG];
        wr_evt.evt_ack     = sel[RG_EVT]     && bus_wdata[0];                 // R10
        wr_evt.mask_wr     = sel[RG_MASK];
        wr_evt.force_set   = sel[RG_FORCE]   && bus_wdata[0];                 // R11
    end

endmodule

// File: rtl/kwd_ctrl_fsm.sv
module kwd_ctrl_fsm
    import kwd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wr_evt_t wr_evt,
    output logic    running,
    output logic    armed
);

    wd_state_e state, state_nxt;

    // Next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_OFF: begin
                if (wr_evt.restart_key) state_nxt = S_RUN;           // R4
            end
            S_RUN: begin
                if (wr_evt.dis1_key) state_nxt = S_ARMED;            // R5
            end
            S_ARMED: begin
                if (wr_evt.dis2_key)
                    state_nxt = S_OFF;
                else if (wr_evt.dis2_other || wr_evt.dis1_other)
                    state_nxt = S_RUN;                               // cancel
            end
            default: state_nxt = S_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_OFF;                                  // R1
        else        state <= state_nxt;
    end

    // Outputs
    always_comb begin
        running = 1'b0;
        armed   = 1'b0;
        unique case (state)
            S_OFF:   running = 1'b0;
            S_RUN:   running = 1'b1;
            S_ARMED: begin
                running = 1'b1;
                armed   = 1'b1;
            end
            default: running = 1'b0;
        endcase
    end

endmodule

// File: rtl/kwd_down_counter.sv
module kwd_down_counter #(
    parameter int             CNT_W   = 15,
    parameter logic [CNT_W-1:0] RST_VAL = CNT_W'(6000)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             upd,
    output logic             warn_p,
    output logic             fire_p
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic at_zero, at_one;

    assign at_zero = (count == '0);
    assign at_one  = (count == ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= RST_VAL;
            upd    <= 1'b0;
            warn_p <= 1'b0;
            fire_p <= 1'b0;
        end else begin
            upd    <= load || step;                          // R6
            warn_p <= step && !load && at_one;               // R7
            fire_p <= step && !load && at_zero;              // R8
            if (load)
                count <= load_val;                           // R3: feed wins
            else if (step)
                count <= at_zero ? load_val : count - ONE;   // R4 / R8
        end
    end

endmodule

// File: rtl/kwd_irq_evt.sv
module kwd_irq_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic warn_p,
    input  logic force_set,
    input  logic evt_ack,
    input  logic mask_wr,
    input  logic mask_d,
    output logic evt,
    output logic mask,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt  <= 1'b0;
            mask <= 1'b0;                                    // R1
        end else begin
            if (warn_p || force_set) evt <= 1'b1;            // R7 / R11
            else if (evt_ack)        evt <= 1'b0;            // R10
            if (mask_wr) mask <= mask_d;
        end
    end

    assign irq = evt && mask;                                // R10

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int CNT_W       = 15,
    parameter int RST_TIMEOUT = 6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              dbg_mode,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wdt_reset
);

    localparam logic [CNT_W-1:0] TMO_INIT = CNT_W'(RST_TIMEOUT);

    wr_evt_t          wr_evt;
    logic             running, armed;
    logic [CNT_W-1:0] timeout, count;
    logic             upd, warn_p, fire_p;
    logic             evt, mask;
    logic             status_flag, dbg_en;
    logic             count_gate, step;

    kwd_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr_evt    (wr_evt)
    );

    kwd_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_evt  (wr_evt),
        .running (running),
        .armed   (armed)
    );

    // Debug hold: count only when not in debug, or override set (R12)
    assign count_gate = !dbg_mode || dbg_en;
    assign step       = tick_en && running && count_gate;

    kwd_down_counter #(.CNT_W(CNT_W), .RST_VAL(TMO_INIT)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_evt.feed_key),
        .load_val (timeout),
        .step     (step),
        .count    (count),
        .upd      (upd),
        .warn_p   (warn_p),
        .fire_p   (fire_p)
    );

    kwd_irq_evt u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .warn_p    (warn_p),
        .force_set (wr_evt.force_set),
        .evt_ack   (wr_evt.evt_ack),
        .mask_wr   (wr_evt.mask_wr),
        .mask_d    (bus_wdata[0]),
        .evt       (evt),
        .mask      (mask),
        .irq       (irq)
    );

    assign wdt_reset = fire_p;                                // R8

    // Timeout, sticky status and debug override registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout     <= TMO_INIT;                          // R1
            status_flag <= 1'b0;
            dbg_en      <= 1'b0;
        end else begin
            if (wr_evt.tmo_wr) timeout <= bus_wdata[CNT_W-1:0];   // R2
            if (fire_p)               status_flag <= 1'b1;    // R9
            else if (wr_evt.stat_clr) status_flag <= 1'b0;
            if (wr_evt.dbg_wr) dbg_en <= bus_wdata[0];
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[1:0] == 2'b00) begin
            unique case (bus_addr[ADDR_W-1:2])
                (ADDR_W-2)'(RG_TMO):  bus_rdata[CNT_W-1:0] = timeout;
                (ADDR_W-2)'(RG_DIS2): bus_rdata = running ? CODE_ON : CODE_OFF;
                (ADDR_W-2)'(RG_STAT): bus_rdata = status_flag ? CODE_EXPIRED : CODE_NORMAL;
                (ADDR_W-2)'(RG_CNT): begin
                    bus_rdata[CNT_W-1:0]  = count;
                    bus_rdata[DATA_W-1]   = upd;                  // R6
                end
                (ADDR_W-2)'(RG_DBG): begin
                    bus_rdata[0] = dbg_en;
                    bus_rdata[1] = dbg_mode;                      // R12
                end
                (ADDR_W-2)'(RG_EVT):  bus_rdata[0] = evt;
                (ADDR_W-2)'(RG_MASK): bus_rdata[0] = mask;
                default:              bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/kwd_sva.sv
module kwd_sva #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wdt_reset,
    input logic             running,
    input logic             armed,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] timeout,
    input logic             dbg_mode,
    input logic             dbg_en,
    input logic             feed_key,
    input logic             status_flag
);

    AST_RESET_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |-> (count == $past(timeout)));                          // R8

    AST_RESET_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |-> $past(running));                                     // R4

    AST_OFF_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && $past(running)) |-> $past(armed));                    // R5

    AST_STATUS_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |=> status_flag);                                        // R9

    AST_DEBUG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dbg_mode && !dbg_en && !feed_key) |-> (count == $past(count))); // R12

endmodule

bind keyed_watchdog kwd_sva #(.CNT_W(CNT_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdt_reset   (wdt_reset),
    .running     (running),
    .armed       (armed),
    .count       (count),
    .timeout     (timeout),
    .dbg_mode    (dbg_mode),
    .dbg_en      (dbg_en),
    .feed_key    (wr_evt.feed_key),
    .status_flag (status_flag)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        dbg_mode = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, wdt_reset;

    int total = 0;
    int bad = 0;
    int pulses = 0;

    always #5 clk = ~clk;

    keyed_watchdog u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_mode(dbg_mode),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .wdt_reset(wdt_reset)
    );

    always @(negedge clk) if (rst_n && wdt_reset) pulses++;

    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_TK = 3'd2, OP_IRQ = 3'd3,
                           OP_PUL = 3'd4, OP_IDLE = 3'd5, OP_DBG = 3'd6;

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 69;
    localparam vec_t TBL [NV] = '{
        '{OP_RD,  8'h0C, 16'h0000, 16'hDABE, 8'd1},   // R1
        '{OP_RD,  8'h04, 16'h0000, 16'h1770, 8'd1},
        '{OP_RD,  8'h24, 16'h0000, 16'h0000, 8'd1},
        '{OP_RD,  8'h10, 16'h0000, 16'h0000, 8'd1},
        '{OP_RD,  8'h14, 16'h0000, 16'h1770, 8'd6},   // R6
        '{OP_IRQ, 8'h00, 16'h0000, 16'h0000, 8'd1},
        '{OP_WR,  8'h04, 16'hFFFF, 16'h0000, 8'd2},   // R2
        '{OP_RD,  8'h04, 16'h0000, 16'h7FFF, 8'd2},
        '{OP_WR,  8'h04, 16'h0003, 16'h0000, 8'd2},
        '{OP_RD,  8'h04, 16'h0000, 16'h0003, 8'd2},
        '{OP_TK,  8'h00, 16'h0000, 16'h0000, 8'd4},   // R4 disabled tick
        '{OP_RD,  8'h14, 16'h0000, 16'h1770, 8'd4},
        '{OP_WR,  8'h00, 16'h1234, 16'h0000, 8'd3},   // R3 wrong key
        '{OP_RD,  8'h14, 16'h0000, 16'h1770, 8'd3},
        '{OP_WR,  8'h00, 16'hFEED, 16'h0000, 8'd3},
        '{OP_RD,  8'h14, 16'h0000, 16'h8003, 8'd6},
        '{OP_RD,  8'h14, 16'h0000, 16'h0003, 8'd6},
        '{OP_WR,  8'h1C, 16'hACED, 16'h0000, 8'd4},
        '{OP_RD,  8'h0C, 16'h0000, 16'h0000, 8'd5},   // R5
        '{OP_TK,  8'h00, 16'h0000, 16'h0000, 8'd4},
        '{OP_RD,  8'h14, 16'h0000, 16'h8002, 8'd4},
        '{OP_TK,  8'h00, 16'h0000, 16'h0000, 8'd4},
        '{OP_RD,  8'h14, 16'h0000, 16'h8001, 8'd4},
        '{OP_RD,  8'h20, 16'h0000, 16'h0000, 8'd7},   // R7
        '{OP_TK,  8'h00, 16'h0000, 16'h0000, 8'd7},
        '{OP_RD,  8'h14, 16'h0000, 16'h8000, 8'd7},
        '{OP_RD,  8'h20, 16'h0000, 16'h0001, 8'd7},
        '{OP_PUL, 8'h00, 16'h0000, 16'h0000, 8'd7},
        '{OP_WR,  8'h24, 16'h0001, 16'h0000, 8'd10},  // R10
        '{OP_IRQ, 8'h00, 16'h0000, 16'h0001, 8'd10},
        '{OP_TK,  8'h00, 16'h0000, 16'h0000, 8'd8},   // R8
        '{OP_IDLE,8'h00, 16'h0000, 16'h0000, 8'd8},
        '{OP_RD,  8'h10, 16'h0000, 16'hCFE8, 8'd9},   // R9
        '{OP_RD,  8'h14, 16'h0000, 16'h0003, 8'd8},
        '{OP_PUL, 8'h00, 16'h0000, 16'h0001, 8'd8},
        '{OP_RD,  8'h0C, 16'h0000, 16'h0000, 8'd8},
        '{OP_WR,  8'h20, 16'h0001, 16'h0000, 8'd10},
        '{OP_IRQ, 8'h00, 16'h0000, 16'h0000, 8'd10},
        '{OP_WR,  8'h10, 16'h1111, 16'h0000, 8'd9},
        '{OP_RD,  8'h10, 16'h0000, 16'hCFE8, 8'd9},
        '{OP_WR,  8'h10, 16'hE8B4, 16'h0000, 8'd9},
        '{OP_RD,  8'h10, 16'h0000, 16'h0000, 8'd9},
        '{OP_WR,  8'h28, 16'h0001, 16'h0000, 8'd11},  // R11
        '{OP_IRQ, 8'h00, 16'h0000, 16'h0001, 8'd11},
        '{OP_WR,  8'h20, 16'h0001, 16'h0000, 8'd11},
        '{OP_IRQ, 8'h00, 16'h0000, 16'h0000, 8'd11},
        '{OP_WR,  8'h0C, 16'hCAFE, 16'h0000, 8'd5},   // lone second key
        '{OP_RD,  8'h0C, 16'h0000, 16'h0000, 8'd5},
        '{OP_WR,  8'h08, 16'h2BAD, 16'h0000, 8'd5},
        '{OP_WR,  8'h08, 16'h1111, 16'h0000, 8'd5},   // cancel
        '{OP_WR,  8'h0C, 16'hCAFE, 16'h0000, 8'd5},
        '{OP_RD,  8'h0C, 16'h0000, 16'h0000, 8'd5},
        '{OP_WR,  8'h08, 16'h2BAD, 16'h0000, 8'd5},
        '{OP_WR,  8'h0C, 16'hCAFE, 16'h0000, 8'd5},
        '{OP_RD,  8'h0C, 16'h0000, 16'hDABE, 8'd5},
        '{OP_TK,  8'h00, 16'h0000, 16'h0000, 8'd4},
        '{OP_RD,  8'h14, 16'h0000, 16'h0003, 8'd4},
        '{OP_WR,  8'h1C, 16'hACED, 16'h0000, 8'd4},
        '{OP_DBG, 8'h00, 16'h0001, 16'h0000, 8'd12},  // R12
        '{OP_RD,  8'h18, 16'h0000, 16'h0002, 8'd12},
        '{OP_TK,  8'h00, 16'h0000, 16'h0000, 8'd12},
        '{OP_RD,  8'h14, 16'h0000, 16'h0003, 8'd12},
        '{OP_WR,  8'h18, 16'h0001, 16'h0000, 8'd12},
        '{OP_RD,  8'h18, 16'h0000, 16'h0003, 8'd12},
        '{OP_TK,  8'h00, 16'h0000, 16'h0000, 8'd12},
        '{OP_RD,  8'h14, 16'h0000, 16'h8002, 8'd12},
        '{OP_DBG, 8'h00, 16'h0000, 16'h0000, 8'd12},
        '{OP_WR,  8'h18, 16'h0000, 16'h0000, 8'd12},
        '{OP_RD,  8'h18, 16'h0000, 16'h0000, 8'd12}
    };

    task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d, input logic tk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; tick_en = 1'b0;
    endtask

    task automatic tick();
        tick_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [15:0] exp, input int req);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2ms;
        bad++;
        total++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            unique case (TBL[i].op)
                OP_WR:   bus_write(TBL[i].addr, TBL[i].data, 1'b0);
                OP_RD:   bus_read(TBL[i].addr, TBL[i].exp, int'(TBL[i].req));
                OP_TK:   tick();
                OP_IRQ:  begin
                    #1;
                    check(int'(TBL[i].req), {15'd0, irq}, TBL[i].exp);
                    @(negedge clk);
                end
                OP_PUL:  check(int'(TBL[i].req), 16'(pulses), TBL[i].exp);
                OP_IDLE: @(negedge clk);
                OP_DBG:  begin
                    dbg_mode = TBL[i].data[0];
                    @(negedge clk);
                end
                default: @(negedge clk);
            endcase
        end

        // R3 corner: feed and tick together, feed wins
        bus_write(8'h04, 16'h0005, 1'b0);
        bus_write(8'h00, 16'hFEED, 1'b1);
        bus_read(8'h14, 16'h8005, 3);

        // R1 corner: reset in the middle of a run
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_read(8'h0C, 16'hDABE, 1);
        bus_read(8'h04, 16'h1770, 1);
        bus_read(8'h24, 16'h0000, 1);
        bus_read(8'h10, 16'h0000, 1);
        check(1, {14'd0, irq, wdt_reset}, 16'h0000);

        finish_run();
    end

endmodule